// File: doc/BRIEF.md
# SDRAM Auto-Refresh Scheduler

This block decides when an SDRAM controller sends auto-refresh commands to the memory. A free-running interval counter, loaded from a programmable count, raises one refresh deadline each time the count elapses. When the access sequencer reports that no transfer is in progress, the block takes the command pins. It precharges every bank, waits the programmed precharge time, and issues an auto-refresh. It then waits the programmed refresh cycle time and hands the pins back with the memory idle. The next access must therefore start with a bank activate.

A deadline that falls during a transfer is not lost. It is counted in a small saturating backlog, and the block raises a hold request so that the sequencer starts nothing new once the current transfer ends. The interval counter never stops or restarts for a waiting refresh, so late refreshes do not move later deadlines. When several deadlines have piled up, the block issues one precharge and then the refreshes back to back. A count of zero switches refresh generation off. The reset input is asynchronous and active low, and it must be deasserted in step with the clock.

Top module: `sdram_refresh_sched`

## Requirements
- R1: While reset is asserted, the command pins carry NOP, encoded {cs_n,ras_n,cas_n,we_n} = 4'b0111, with a10 low, and ref_req and ref_active are low.
- R2: With a nonzero cfg_interval held from reset release, a deadline falls on every cfg_interval-th clock edge. Each deadline produces exactly one refresh command, so N edges yield N/cfg_interval (rounded down) refreshes.
- R3: A cfg_interval of zero creates no deadlines. With no backlog, only NOP is driven and ref_req stays low.
- R4: A refresh sequence starts only on a clock edge where acc_idle is high. No command other than NOP appears while acc_idle is low and the block is not active. Deadlines that fall during a transfer are all served once it ends.
- R5: The interval counter keeps running while a refresh is waiting, so deadlines after a deferral stay on the original grid of cfg_interval cycles.
- R6: ref_req is high from the cycle after a deadline until the refresh sequence serving the backlog has finished.
- R7: Every refresh sequence opens with a precharge-all command, 4'b0010 with a10 high. The first refresh follows it exactly cfg_trp+1 cycles later, and no refresh is ever issued without a preceding precharge since the last transfer.
- R8: The refresh command is 4'b0001. After each refresh, cfg_trfc NOP cycles follow. The next refresh comes on the cycle after that if a backlog remains; otherwise ref_active falls on that cycle.
- R9: The backlog saturates at 8. However many deadlines pass during one long transfer, at most 8 refreshes follow it.
- R10: a10 is high only in cycles that carry the precharge-all command.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| cfg_interval | input | 16 | Refresh interval in clock cycles; zero disables refresh |
| cfg_trp | input | 4 | NOP cycles between precharge-all and refresh |
| cfg_trfc | input | 6 | NOP cycles after each refresh |
| acc_idle | input | 1 | High when the access sequencer has no transfer in progress |
| ref_req | output | 1 | Hold and request toward the sequencer: refresh pending or running |
| ref_active | output | 1 | High while this block drives the command pins |
| cmd_o | output | 4 | Command {cs_n, ras_n, cas_n, we_n} |
| a10_o | output | 1 | Address bit 10 (all-banks select during precharge) |

## Verification
A wrong interval count would show up within one interval, as a refresh that is off the grid or missing. It would also show up over a long run as a refresh total that differs from the floor of cycles divided by the interval. A broken backlog counter shows in the number of refreshes that follow a long transfer: three deferred deadlines must give exactly three refreshes and ten must give eight. Later precharges must also keep the phase they had before the deferral. A corrupted wait counter or state shows on the very next refresh sequence, as a wrong spacing between precharge and refresh or between refresh and release. It can also show as a refresh with no precharge before it, or as a command driven while a transfer holds the pins.

// File: rtl/sdram_refresh_pkg.sv
package sdram_refresh_pkg;

  typedef enum logic [2:0] {
    RS_IDLE,
    RS_PALL,
    RS_WAIT_RP,
    RS_REF,
    RS_WAIT_RFC
  } rs_state_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP  = 4'b0111;
  localparam logic [3:0] CMD_PALL = 4'b0010;
  localparam logic [3:0] CMD_REF  = 4'b0001;

endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_interval,
  output logic             deadline_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  // Free-running: never paused by a pending refresh.
  always_comb begin
    cnt_d      = cnt_q;
    deadline_o = 1'b0;
    if (cfg_interval == '0) begin
      cnt_d = '0;
    end else if (cnt_q >= cfg_interval - CNT_W'(1)) begin
      deadline_o = 1'b1;
      cnt_d      = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TMR_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    $past(deadline_o) && (cfg_interval > CNT_W'(1)) && $stable(cfg_interval) |-> !deadline_o); // R2

endmodule

// File: rtl/refresh_pending_ctr.sv
module refresh_pending_ctr #(
  parameter int PEND_MAX = 8,
  localparam int PEND_W  = $clog2(PEND_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              deadline_i,
  input  logic              issue_i,
  output logic [PEND_W-1:0] pend_q,
  output logic [PEND_W-1:0] pend_next
);

  always_comb begin
    pend_next = pend_q;
    unique case ({deadline_i, issue_i})
      2'b10: if (pend_q != PEND_W'(PEND_MAX)) pend_next = pend_q + PEND_W'(1);
      2'b01: if (pend_q != '0)                pend_next = pend_q - PEND_W'(1);
      default: pend_next = pend_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_next;
  end

  AST_PEND_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == PEND_W'(PEND_MAX)) && deadline_i && !issue_i |=> pend_q == PEND_W'(PEND_MAX)); // R9
  AST_PEND_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i && !deadline_i |=> pend_q == $past(pend_q) - PEND_W'(1)); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |-> pend_q != '0); // R8

endmodule

// File: rtl/refresh_cmd_fsm.sv
module refresh_cmd_fsm
  import sdram_refresh_pkg::*;
#(
  parameter int TRP_W  = 4,
  parameter int TRFC_W = 6,
  parameter int PEND_W = 4,
  localparam int WAIT_W = (TRP_W > TRFC_W) ? TRP_W : TRFC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TRP_W-1:0]  cfg_trp,
  input  logic [TRFC_W-1:0] cfg_trfc,
  input  logic [PEND_W-1:0] pend_q,
  input  logic [PEND_W-1:0] pend_next,
  input  logic              acc_idle_i,
  output logic              issue_o,
  output logic              active_o,
  output logic [3:0]        cmd_o,
  output logic              a10_o
);

  rs_state_e         state_q, state_d;
  logic [WAIT_W-1:0] wcnt_q, wcnt_d;

  always_comb begin
    state_d = state_q;
    wcnt_d  = wcnt_q;
    issue_o = 1'b0;
    unique case (state_q)
      RS_IDLE: begin
        if ((pend_q != '0) && acc_idle_i) state_d = RS_PALL;
      end
      RS_PALL: begin
        wcnt_d  = WAIT_W'(cfg_trp);
        state_d = (cfg_trp == '0) ? RS_REF : RS_WAIT_RP;
      end
      RS_WAIT_RP: begin
        if (wcnt_q == WAIT_W'(1)) state_d = RS_REF;
        else                      wcnt_d  = wcnt_q - WAIT_W'(1);
      end
      RS_REF: begin
        issue_o = 1'b1;
        wcnt_d  = WAIT_W'(cfg_trfc);
        if (cfg_trfc != '0)        state_d = RS_WAIT_RFC;
        else if (pend_next != '0)  state_d = RS_REF;
        else                       state_d = RS_IDLE;
      end
      RS_WAIT_RFC: begin
        if (wcnt_q == WAIT_W'(1)) state_d = (pend_next != '0) ? RS_REF : RS_IDLE;
        else                      wcnt_d  = wcnt_q - WAIT_W'(1);
      end
      default: state_d = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RS_IDLE;
      wcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      wcnt_q  <= wcnt_d;
    end
  end

  always_comb begin
    unique case (state_q)
      RS_PALL: cmd_o = CMD_PALL;
      RS_REF:  cmd_o = CMD_REF;
      default: cmd_o = CMD_NOP;
    endcase
  end

  assign a10_o    = (state_q == RS_PALL);
  assign active_o = (state_q != RS_IDLE);

  AST_REF_PREPARED: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == RS_REF |-> $past(state_q) != RS_IDLE); // R7
  AST_PALL_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == RS_PALL |=> (state_q == RS_WAIT_RP) || (state_q == RS_REF)); // R7
  AST_START_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_o) |-> $past(acc_idle_i) && ($past(pend_q) != '0)); // R4

endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched
  import sdram_refresh_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int TRP_W    = 4,
  parameter int TRFC_W   = 6,
  parameter int PEND_MAX = 8,
  localparam int PEND_W  = $clog2(PEND_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cfg_interval,
  input  logic [TRP_W-1:0]  cfg_trp,
  input  logic [TRFC_W-1:0] cfg_trfc,
  input  logic              acc_idle,
  output logic              ref_req,
  output logic              ref_active,
  output logic [3:0]        cmd_o,
  output logic              a10_o
);

  logic              deadline;
  logic              issue;
  logic [PEND_W-1:0] pend_q;
  logic [PEND_W-1:0] pend_next;

  refresh_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_interval (cfg_interval),
    .deadline_o   (deadline)
  );

  refresh_pending_ctr #(.PEND_MAX(PEND_MAX)) u_pending (
    .clk        (clk),
    .rst_n      (rst_n),
    .deadline_i (deadline),
    .issue_i    (issue),
    .pend_q     (pend_q),
    .pend_next  (pend_next)
  );

  refresh_cmd_fsm #(.TRP_W(TRP_W), .TRFC_W(TRFC_W), .PEND_W(PEND_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_trp    (cfg_trp),
    .cfg_trfc   (cfg_trfc),
    .pend_q     (pend_q),
    .pend_next  (pend_next),
    .acc_idle_i (acc_idle),
    .issue_o    (issue),
    .active_o   (ref_active),
    .cmd_o      (cmd_o),
    .a10_o      (a10_o)
  );

  assign ref_req = (pend_q != '0) || ref_active;

  AST_QUIET_DURING_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_idle && !ref_active |-> cmd_o == CMD_NOP); // R4
  AST_OFF_STAYS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_interval == '0) && (pend_q == '0) && !ref_active |=> !ref_req && (cmd_o == CMD_NOP)); // R3
  AST_A10_ONLY_PALL: assert property (@(posedge clk) disable iff (!rst_n)
    a10_o |-> cmd_o == CMD_PALL); // R10

endmodule

// File: tb/sdram_refresh_sched_tb.sv
module sdram_refresh_sched_tb;

  localparam int TCLK = 10;
  localparam logic [3:0] NOP  = 4'b0111;
  localparam logic [3:0] PALL = 4'b0010;
  localparam logic [3:0] REFC = 4'b0001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_interval = '0;
  logic [3:0]  cfg_trp = '0;
  logic [5:0]  cfg_trfc = '0;
  logic        acc_idle = 1'b1;
  logic        ref_req, ref_active, a10;
  logic [3:0]  cmd;

  int total = 0, bad = 0, wd = 0;
  int cyc, n_pall, n_ref, pall_cyc, ref_cyc, pall_gap, last_ev;
  bit prech, act_prev;
  int p_first, r0, q0, iv, nrun, busy_left;

  always #(TCLK/2) clk = ~clk;

  sdram_refresh_sched u_dut (
    .clk (clk), .rst_n (rst_n), .cfg_interval (cfg_interval),
    .cfg_trp (cfg_trp), .cfg_trfc (cfg_trfc), .acc_idle (acc_idle),
    .ref_req (ref_req), .ref_active (ref_active), .cmd_o (cmd), .a10_o (a10)
  );

  function automatic int exp_refs(int edges, int interval);
    return edges / interval;
  endfunction

  function automatic int exp_backlog(int deadlines);
    return (deadlines > 8) ? 8 : deadlines;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(int ivl, int trp, int trfc, bit idle);
    rst_n = 1'b0;
    cfg_interval = 16'(ivl);
    cfg_trp = 4'(trp);
    cfg_trfc = 6'(trfc);
    acc_idle = idle;
    repeat (3) @(negedge clk);
    chk(cmd == NOP && !a10, "R1 reset command", int'(cmd), int'(NOP));
    chk(!ref_req && !ref_active, "R1 reset req/active", int'({ref_req, ref_active}), 0);
    rst_n = 1'b1;
  endtask

  // Monitor: samples a quarter period after each rising edge.
  always @(posedge clk) begin
    #(TCLK/4);
    if (!rst_n) begin
      cyc = 0; n_pall = 0; n_ref = 0; prech = 0; last_ev = 0;
      act_prev = 0; pall_gap = 0; pall_cyc = 0; ref_cyc = 0;
    end else begin
      cyc++;
      if (!acc_idle && cmd != NOP) chk(0, "R4 command during transfer", int'(cmd), int'(NOP));
      if (cmd == PALL) begin
        chk(a10, "R10 a10 on precharge", int'(a10), 1);
        if (n_pall > 0) pall_gap = cyc - pall_cyc;
        pall_cyc = cyc; n_pall++; prech = 1; last_ev = 1;
      end else if (cmd == REFC) begin
        chk(!a10, "R10 a10 on refresh", int'(a10), 0);
        chk(prech, "R7 refresh without precharge", int'(prech), 1);
        if (last_ev == 1) chk(cyc - pall_cyc == int'(cfg_trp) + 1, "R7 precharge-to-refresh", cyc - pall_cyc, int'(cfg_trp) + 1);
        else chk(cyc - ref_cyc == int'(cfg_trfc) + 1, "R8 refresh-to-refresh", cyc - ref_cyc, int'(cfg_trfc) + 1);
        ref_cyc = cyc; n_ref++; last_ev = 2;
      end else if (cmd != NOP) begin
        chk(0, "R8 illegal command code", int'(cmd), int'(NOP));
      end
      if (!acc_idle) prech = 0;
      if (act_prev && !ref_active) chk(cyc - ref_cyc == int'(cfg_trfc) + 1, "R8 release timing", cyc - ref_cyc, int'(cfg_trfc) + 1);
      act_prev = ref_active;
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 190000) begin
      bad++; total++;
      $display("FAIL R2 watchdog expired act=%0d exp<190000", wd);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));

    // R3: disabled refresh
    do_reset(0, 1, 2, 1);
    repeat (500) @(negedge clk);
    chk(n_pall == 0 && n_ref == 0, "R3 no commands when interval is zero", n_pall + n_ref, 0);
    chk(!ref_req, "R3 no request when interval is zero", int'(ref_req), 0);

    // R2: regular spacing, always idle
    do_reset(20, 2, 3, 1);
    while (n_pall < 5) @(negedge clk);
    chk(pall_gap == 20, "R2 deadline spacing", pall_gap, 20);
    repeat (10) @(negedge clk);
    chk(n_ref == n_pall, "R2 one refresh per deadline", n_ref, n_pall);

    // R4/R5/R6: deferral behind a long transfer keeps the grid
    do_reset(200, 1, 2, 1);
    while (n_pall < 1) @(negedge clk);
    p_first = pall_cyc;
    while (ref_active) @(negedge clk);
    r0 = n_ref; q0 = n_pall;
    acc_idle = 1'b0;
    repeat (610) @(negedge clk);
    chk(ref_req, "R6 hold raised while deferred", int'(ref_req), 1);
    chk(n_ref == r0, "R4 nothing issued during transfer", n_ref - r0, 0);
    acc_idle = 1'b1;
    repeat (100) @(negedge clk);
    chk(n_ref - r0 == exp_backlog(3), "R4 deferred refreshes served", n_ref - r0, exp_backlog(3));
    chk(n_pall - q0 == 1, "R7 one precharge per burst", n_pall - q0, 1);
    chk(!ref_req, "R6 hold dropped after drain", int'(ref_req), 0);
    while (n_pall == q0 + 1) @(negedge clk);
    chk((pall_cyc - p_first) % 200 == 0, "R5 grid phase kept", (pall_cyc - p_first) % 200, 0);

    // R9: saturation after ten missed deadlines
    do_reset(200, 1, 2, 0);
    repeat (2010) @(negedge clk);
    acc_idle = 1'b1;
    repeat (150) @(negedge clk);
    chk(n_ref == exp_backlog(10), "R9 backlog saturates", n_ref, exp_backlog(10));

    // R2/R4: random transfers against the long-run refresh count
    for (int t = 0; t < 6; t++) begin
      iv = 30 + int'($urandom % 31);
      nrun = 400 + int'($urandom % 300);
      do_reset(iv, int'($urandom % 4), int'($urandom % 7), 1);
      busy_left = 0;
      for (int i = 0; i < nrun; i++) begin
        @(negedge clk);
        if (busy_left > 0) begin
          busy_left--;
          if (busy_left == 0) acc_idle = 1'b1;
        end else if (!ref_req && ($urandom % 6 == 0)) begin
          acc_idle = 1'b0;
          busy_left = 1 + int'($urandom % (iv / 3));
        end
      end
      cfg_interval = '0;
      while (busy_left > 0) begin
        @(negedge clk);
        busy_left--;
      end
      acc_idle = 1'b1;
      repeat (60) @(negedge clk);
      chk(n_ref == exp_refs(nrun, iv), "R2 long-run refresh count", n_ref, exp_refs(nrun, iv));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule